// File: doc/BRIEF.md
# Pin Event Interrupt Collector

This block watches a bank of 32 pin inputs, which arrive already synchronized to the system clock, and turns level and edge conditions on them into pending interrupt events. Each pin picks its own trigger condition with a 3-bit selector. Each pin can also have a glitch filter that is paced by a slow-clock enable pulse. Every detected event sets a bit in a pending-status register. Software reads that register to learn which pins fired, and the read also clears it. There is no separate acknowledge step.

An enable mask decides which pending bits reach the single bank interrupt line. Software sets mask bits through one write-one register and clears them through another. It can read the mask back at a third offset. The per-pin trigger selectors and filter controls come from an external configuration store and are inputs here.

Top module: `gpio_evt_aggr`

## Requirements
- R1: After reset the mask (offset 0x28) and pending status (offset 0x2C) both read zero and `irq_out` is low. Filtered pin levels start low.
- R2: A write to offset 0x20 sets every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R3: A write to offset 0x24 clears every mask bit whose data bit is 1. Other mask bits keep their value.
- R4: Selector 0 records a falling edge, 1 a rising edge and 2 either edge. An edge is a difference between the filtered level and its value one cycle earlier. With filtering off, the status bit is readable after the second rising clock edge that follows the input change. A pending bit stays set until a status read.
- R5: Selector 3 (low level) and selector 4 (high level) set the status bit on every cycle in which the condition holds. A read therefore finds the bit pending again while the level persists.
- R6: Selector codes 5, 6 and 7 never record an event, whatever the pin does.
- R7: A read of offset 0x2C returns the pending bits and clears them. An event detected in the same cycle as the read stays pending afterwards.
- R8: Events are recorded whatever the mask holds. `irq_out` is high exactly while some pending bit has its mask bit set.
- R9: When a pin's `filt_en` and `filt_slow` bits are both 1, a new input level reaches the detector only after it has held through two consecutive `slow_tick` pulses. A shorter excursion is dropped. With either bit at 0 the pin is unfiltered.
- R10: Writes to offsets 0x28 and 0x2C change neither the mask nor the pending status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status at offset 0x2C) |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the addressed register |
| pin_in | input | NPIN | Synchronized pin levels |
| evt_sel | input | NPIN*3 | Per-pin trigger selector, pin k at bits [3k+2:3k] |
| filt_en | input | NPIN | Per-pin filter enable |
| filt_slow | input | NPIN | Per-pin slow-clock filter select |
| slow_tick | input | 1 | One-cycle slow-clock enable pulse |
| irq_out | output | 1 | Combined bank interrupt |

## Verification
A corrupted mask bit shows on `irq_out` in the same cycle, and on the next read of offset 0x28. A pending bit that is lost, or that wrongly survives a read, shows on the very next status read. A wrong filter counter or a wrong previous-level register changes when a status bit appears, by at least one cycle or one slow tick. The bench therefore samples status at exact cycle offsets from each pin change and from each tick. It covers edge, level and dead selector codes, reads that coincide with events, and a pulse that ends between ticks.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
   localparam int EVT_SEL_W = 3;

   typedef enum logic [EVT_SEL_W-1:0] {
      EV_FALL = 3'd0,
      EV_RISE = 3'd1,
      EV_BOTH = 3'd2,
      EV_LOW  = 3'd3,
      EV_HIGH = 3'd4
   } evt_kind_e;

   localparam int OFS_ENA = 'h20;
   localparam int OFS_DIS = 'h24;
   localparam int OFS_MSK = 'h28;
   localparam int OFS_STA = 'h2C;
endpackage

// File: rtl/evt_glitch_filter.sv
module evt_glitch_filter #(
   parameter int STABLE_TICKS = 2,
   parameter bit HAS_FILTER   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic flt_on_i,
   input  logic slow_tick_i,
   output logic lvl_o
);
   localparam int CNT_W = (STABLE_TICKS > 1) ? $clog2(STABLE_TICKS) : 1;

   if (STABLE_TICKS < 1) begin : g_bad_ticks
      $error("STABLE_TICKS must be at least 1");
   end

   if (HAS_FILTER) begin : g_filt
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lvl_o <= 1'b0;
            cnt_q <= '0;
         end else if (!flt_on_i) begin
            lvl_o <= raw_i;
            cnt_q <= '0;
         end else if (raw_i == lvl_o) begin
            cnt_q <= '0;
         end else if (slow_tick_i) begin
            if (cnt_q == CNT_W'(STABLE_TICKS - 1)) begin
               lvl_o <= raw_i;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end

      // R9
      hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flt_on_i && !slow_tick_i) |=> (lvl_o == $past(lvl_o)));
   end else begin : g_bypass
      always_ff @(posedge clk) begin
         if (!rst_n) lvl_o <= 1'b0;
         else        lvl_o <= raw_i;
      end
   end
endmodule

// File: rtl/evt_detect.sv
module evt_detect
   import gpio_evt_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 lvl_i,
   input  logic [EVT_SEL_W-1:0] sel_i,
   output logic                 evt_o
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   always_comb begin
      case (evt_kind_e'(sel_i))
         EV_FALL: evt_o = prev_q & ~lvl_i;
         EV_RISE: evt_o = ~prev_q & lvl_i;
         EV_BOTH: evt_o = prev_q ^ lvl_i;
         EV_LOW:  evt_o = ~lvl_i;
         EV_HIGH: evt_o = lvl_i;
         default: evt_o = 1'b0;
      endcase
   end

   // R4
   edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel_i == EV_RISE || sel_i == EV_FALL || sel_i == EV_BOTH) && $stable(lvl_i)) |-> !evt_o);
endmodule

// File: rtl/evt_status_regs.sv
module evt_status_regs
   import gpio_evt_pkg::*;
#(
   parameter int NPIN   = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NPIN-1:0]   evt_i,
   output logic              irq_o
);
   logic [NPIN-1:0] mask_q, status_q, wbits;
   logic hit_ena, hit_dis, hit_sta_rd;

   assign wbits      = reg_wdata[NPIN-1:0];
   assign hit_ena    = reg_wr && (reg_addr == ADDR_W'(OFS_ENA));
   assign hit_dis    = reg_wr && (reg_addr == ADDR_W'(OFS_DIS));
   assign hit_sta_rd = reg_rd && (reg_addr == ADDR_W'(OFS_STA));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q   <= '0;
         status_q <= '0;
      end else begin
         if (hit_ena)      mask_q <= mask_q | wbits;
         else if (hit_dis) mask_q <= mask_q & ~wbits;
         status_q <= (hit_sta_rd ? '0 : status_q) | evt_i;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(OFS_MSK))      reg_rdata = DATA_W'(mask_q);
      else if (reg_addr == ADDR_W'(OFS_STA)) reg_rdata = DATA_W'(status_q);
   end

   assign irq_o = |(status_q & mask_q);

   // R2
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_ena |=> ((mask_q & $past(wbits)) == $past(wbits)));
   // R3
   mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_dis |=> ((mask_q & $past(wbits)) == '0));
   // R7
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_sta_rd && evt_i == '0) |=> (status_q == '0));
   // R7
   evt_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));
   // R4
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_sta_rd |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/gpio_evt_aggr.sv
module gpio_evt_aggr
   import gpio_evt_pkg::*;
#(
   parameter int NPIN         = 32,
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 8,
   parameter int STABLE_TICKS = 2,
   parameter bit HAS_FILTER   = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_wr,
   input  logic                      reg_rd,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic [DATA_W-1:0]         reg_wdata,
   output logic [DATA_W-1:0]         reg_rdata,
   input  logic [NPIN-1:0]           pin_in,
   input  logic [NPIN*EVT_SEL_W-1:0] evt_sel,
   input  logic [NPIN-1:0]           filt_en,
   input  logic [NPIN-1:0]           filt_slow,
   input  logic                      slow_tick,
   output logic                      irq_out
);
   if (NPIN < 1 || NPIN > DATA_W) begin : g_bad_npin
      $error("NPIN must lie in 1..DATA_W");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W too narrow for the register offsets");
   end

   logic [NPIN-1:0] lvl, evt;

   for (genvar k = 0; k < NPIN; k++) begin : g_pin
      evt_glitch_filter #(
         .STABLE_TICKS (STABLE_TICKS),
         .HAS_FILTER   (HAS_FILTER)
      ) u_flt (
         .clk         (clk),
         .rst_n       (rst_n),
         .raw_i       (pin_in[k]),
         .flt_on_i    (filt_en[k] & filt_slow[k]),
         .slow_tick_i (slow_tick),
         .lvl_o       (lvl[k])
      );

      evt_detect u_det (
         .clk   (clk),
         .rst_n (rst_n),
         .lvl_i (lvl[k]),
         .sel_i (evt_sel[k*EVT_SEL_W +: EVT_SEL_W]),
         .evt_o (evt[k])
      );
   end

   evt_status_regs #(
      .NPIN   (NPIN),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .evt_i     (evt),
      .irq_o     (irq_out)
   );
endmodule

// File: tb/sim_gpio_evt_aggr.sv
module sim_gpio_evt_aggr;
   localparam int NPIN = 32;
   localparam int DW   = 32;
   localparam int AW   = 8;
   localparam int SW   = 3;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, reg_wr, reg_rd, slow_tick;
   logic [AW-1:0] reg_addr;
   logic [DW-1:0] reg_wdata;
   wire  [DW-1:0] reg_rdata;
   logic [NPIN-1:0] pin_in, filt_en, filt_slow;
   logic [NPIN*SW-1:0] evt_sel;
   wire irq_out;

   gpio_evt_aggr u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pin_in(pin_in), .evt_sel(evt_sel), .filt_en(filt_en),
      .filt_slow(filt_slow), .slow_tick(slow_tick), .irq_out(irq_out)
   );

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } sb_item_t;

   sb_item_t sb[$];
   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // monitor: compares queued expectations 3 ns after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #3;
         while (sb.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            act = it.is_irq ? {31'b0, irq_out} : reg_rdata;
            n_run++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
      sb_item_t it;
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      it.is_irq = 1'b0; it.exp = e; it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic irq_chk(input logic e, input string tag);
      sb_item_t it;
      it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic set_sel(input int idx, input logic [2:0] v);
      evt_sel[idx*SW +: SW] = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_tick();
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
      pin_in = '0; filt_en = '0; filt_slow = '0; slow_tick = 1'b0;
      evt_sel = {NPIN{3'b101}};
      idle(3);
      rst_n = 1'b1;

      // R1 reset state
      rd_chk(8'h28, 32'h0, "R1 mask");
      rd_chk(8'h2C, 32'h0, "R1 status");
      irq_chk(1'b0, "R1 irq");

      // R2 / R3 mask set and clear, R10 write to mask offset ignored
      wr_reg(8'h20, 32'h0000_00F0);
      rd_chk(8'h28, 32'h0000_00F0, "R2 set");
      wr_reg(8'h20, 32'h0000_0003);
      rd_chk(8'h28, 32'h0000_00F3, "R2 zeros keep");
      wr_reg(8'h24, 32'h0000_0030);
      rd_chk(8'h28, 32'h0000_00C3, "R3 clear");
      wr_reg(8'h28, 32'hFFFF_FFFF);
      rd_chk(8'h28, 32'h0000_00C3, "R10 mask write");

      // R4 edge kinds
      @(negedge clk);
      set_sel(0, 3'd1); set_sel(1, 3'd0); set_sel(2, 3'd2);
      @(negedge clk);
      pin_in[2:0] = 3'b111;
      idle(2);
      rd_chk(8'h2C, 32'h0000_0005, "R4 rise");
      @(negedge clk);
      pin_in[2:0] = 3'b000;
      idle(2);
      rd_chk(8'h2C, 32'h0000_0006, "R4 fall");
      rd_chk(8'h2C, 32'h0000_0000, "R7 cleared");

      // R8 unmasked event recorded, irq only for masked-in bits; R10 status write
      @(negedge clk);
      set_sel(3, 3'd1);
      @(negedge clk);
      pin_in[3] = 1'b1;
      idle(2);
      wr_reg(8'h2C, 32'hFFFF_FFFF);
      irq_chk(1'b0, "R8 masked out");
      rd_chk(8'h2C, 32'h0000_0008, "R10 status write");
      @(negedge clk);
      pin_in[0] = 1'b1;
      idle(2);
      irq_chk(1'b1, "R8 irq raised");
      rd_chk(8'h2C, 32'h0000_0001, "R8 status");
      irq_chk(1'b0, "R8 irq after read");

      // R5 high level re-raises
      @(negedge clk);
      set_sel(4, 3'd4);
      @(negedge clk);
      pin_in[4] = 1'b1;
      idle(2);
      rd_chk(8'h2C, 32'h0000_0010, "R5 high");
      rd_chk(8'h2C, 32'h0000_0010, "R5 high again");
      @(negedge clk);
      pin_in[4] = 1'b0;
      idle(2);
      rd_chk(8'h2C, 32'h0000_0010, "R5 last");
      rd_chk(8'h2C, 32'h0000_0000, "R5 gone");
      @(negedge clk);
      set_sel(4, 3'd5);

      // R5 low level
      @(negedge clk);
      set_sel(5, 3'd3);
      rd_chk(8'h2C, 32'h0000_0020, "R5 low");
      @(negedge clk);
      set_sel(5, 3'd5);
      rd_chk(8'h2C, 32'h0000_0020, "R5 low again");
      rd_chk(8'h2C, 32'h0000_0000, "R5 low gone");

      // R7 event in the same cycle as the read
      @(negedge clk);
      set_sel(6, 3'd1);
      @(negedge clk);
      pin_in[6] = 1'b1;
      rd_chk(8'h2C, 32'h0000_0000, "R7 read during event");
      rd_chk(8'h2C, 32'h0000_0040, "R7 event kept");

      // R6 dead codes
      @(negedge clk);
      set_sel(8, 3'd7); set_sel(9, 3'd6);
      @(negedge clk);
      pin_in[9:7] = 3'b111;
      idle(3);
      pin_in[9:7] = 3'b000;
      idle(3);
      rd_chk(8'h2C, 32'h0000_0000, "R6 no events");

      // R9 filtered pin
      @(negedge clk);
      set_sel(10, 3'd1); filt_en[10] = 1'b1; filt_slow[10] = 1'b1;
      @(negedge clk);
      pin_in[10] = 1'b1;
      pulse_tick();
      rd_chk(8'h2C, 32'h0000_0000, "R9 one tick");
      @(negedge clk);
      pin_in[10] = 1'b0;
      pulse_tick();
      pulse_tick();
      rd_chk(8'h2C, 32'h0000_0000, "R9 short pulse dropped");
      @(negedge clk);
      pin_in[10] = 1'b1;
      pulse_tick();
      pulse_tick();
      rd_chk(8'h2C, 32'h0000_0400, "R9 passed after two ticks");

      // R9 filter enable without slow select is unfiltered
      @(negedge clk);
      set_sel(11, 3'd1); filt_en[11] = 1'b1;
      @(negedge clk);
      pin_in[11] = 1'b1;
      idle(2);
      rd_chk(8'h2C, 32'h0000_0800, "R9 bypass");

      idle(2);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule